// File: doc/BRIEF.md
# Chip Power Mode Sequencer

This block steps a chip through five power modes: off, deep sleep, sleep, wakeup and on. It runs on the always-on slow clock. An active-low power-down pin forces it into the off mode and clears everything. When the pin is released, the block starts a wakeup. During wakeup the crystal oscillator, the PLL and the main power domain are switched on, and the block counts a programmable number of slow clock cycles while the crystal settles. Only then does it enter the on mode.

In the on mode, each block receives the high-speed clock only if its bit in a clock control word is set. Gating is done per block, with an enable latch that is transparent only while the high-speed clock is low. The on mode offers two ways out. A light sleep turns off the crystal and PLL but keeps the main domain powered, and any of four wake sources ends it. A deep sleep also removes main-domain power; only the RTC timer or an external interrupt ends it, and the main domain is reset on the way back up.

Top module: `pwr_mode_seq`

## Requirements
- R1: While `chipPdN` is low, the mode is off: `pwrState` is 0, `xtalEn`, `pllEn`, `mainPwrEn` and every bit of `blkClkEn` are low, and `regClear` is high. The input takes effect at once, without waiting for a clock.
- R2: On the first rising clock edge after `chipPdN` goes high, the mode moves from off to wakeup. `regClear` stays high for the whole of that wakeup.
- R3: Wakeup drives `xtalEn`, `pllEn` and `mainPwrEn` high. It lasts exactly N clock cycles and then the mode is on. N is `settleCycles`; a value of 0 selects the default of 64.
- R4: In the on mode, `deepSleepReq` enters deep sleep on the next edge. It has priority over `sleepReq`, which enters sleep. Without either request the mode stays on.
- R5: In sleep, `xtalEn`, `pllEn` and `regClear` are low and `mainPwrEn` is high. A high on any of `wakeMac`, `wakeHost`, `wakeRtc` or `wakeExt` starts a wakeup on the next edge, with `regClear` low throughout that wakeup.
- R6: In deep sleep, `xtalEn`, `pllEn`, `mainPwrEn` and `regClear` are low. `wakeMac` and `wakeHost` have no effect there. Only `wakeRtc` or `wakeExt` starts a wakeup, and `regClear` is high during that wakeup.
- R7: `blkClkEn` equals the value of `clkCtrl` sampled at the last rising edge while the mode is on, and is all zero in every other mode. A change of `clkCtrl` in the on mode shows one cycle later.
- R8: Each bit of `blkClk` is `hsClk` ANDed with that block's enable. The enable is captured only while `hsClk` is low, so a high phase of `hsClk` passes through if the enable was set during the preceding low phase.
- R9: `pwrState` encodes the mode as off=0, deep sleep=1, sleep=2, wakeup=3, on=4.
- R10: `sleepReq` and `deepSleepReq` have no effect outside the on mode. A wakeup still runs its full settle count and ends in the on mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on slow clock |
| chipPdN | input | 1 | Power-down pin, active low, asynchronous |
| sleepReq | input | 1 | Request light sleep |
| deepSleepReq | input | 1 | Request deep sleep |
| wakeMac | input | 1 | Wake event from the MAC |
| wakeHost | input | 1 | Wake event from the host |
| wakeRtc | input | 1 | Wake event from the RTC timer |
| wakeExt | input | 1 | Wake event from an external interrupt |
| settleCycles | input | 16 | Crystal settle length in clock cycles, 0 selects 64 |
| clkCtrl | input | 8 | Per-block clock enable word |
| hsClk | input | 1 | High-speed clock to be gated |
| xtalEn | output | 1 | Crystal oscillator enable |
| pllEn | output | 1 | PLL enable |
| mainPwrEn | output | 1 | Main power domain enable |
| regClear | output | 1 | Global register clear for the main domain |
| blkClkEn | output | 8 | Per-block clock enables in effect |
| blkClk | output | 8 | Per-block gated high-speed clocks |
| pwrState | output | 3 | Current mode code |

## Verification
A wrong mode register shows up on `pwrState` and on the power enables at the next sample after the faulty edge. The bench compares every mode code and every enable after each clock. A settle counter that is off by even one cycle moves the entry into the on mode by that cycle, so the wakeup length is checked exactly for settle counts of 3, 1 and the default of 64. A stale wake-clear flag shows up as a wrong `regClear` in the very first wakeup cycle. A wrongly timed gate latch shows up as a `blkClk` high phase that does not match the enable seen in the preceding low phase.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  typedef enum logic [2:0] {
    PS_OFF   = 3'd0,
    PS_DEEP  = 3'd1,
    PS_SLEEP = 3'd2,
    PS_WAKE  = 3'd3,
    PS_ON    = 3'd4
  } pwrState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic cntClear;  // restart settle count
    logic cntStep;   // advance settle count
    logic clrSet;    // wakeup must reset main domain
    logic clrDrop;   // wakeup keeps main domain state
    logic gateLoad;  // next cycle is on: take clock control word
  } seqStrobe_t;

endpackage

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
(
  input  logic       clk,
  input  logic       chipPdN,
  input  logic       sleepReq,
  input  logic       deepSleepReq,
  input  logic       wakeMac,
  input  logic       wakeHost,
  input  logic       wakeRtc,
  input  logic       wakeExt,
  input  logic       settleDone,
  input  logic       clrHeld,
  output pwrState_t  stateQ,
  output seqStrobe_t strobe,
  output logic       xtalEn,
  output logic       pllEn,
  output logic       mainPwrEn,
  output logic       regClear
);

  pwrState_t stateNext;
  logic anyWake;
  logic deepWake;

  assign anyWake  = wakeMac | wakeHost | wakeRtc | wakeExt;
  assign deepWake = wakeRtc | wakeExt;

  always_comb begin
    stateNext = stateQ;
    unique case (stateQ)
      PS_OFF:   stateNext = PS_WAKE;
      PS_WAKE:  if (settleDone) stateNext = PS_ON;
      PS_ON: begin
        if (deepSleepReq)  stateNext = PS_DEEP;
        else if (sleepReq) stateNext = PS_SLEEP;
      end
      PS_SLEEP: if (anyWake)  stateNext = PS_WAKE;
      PS_DEEP:  if (deepWake) stateNext = PS_WAKE;
      default:  stateNext = PS_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge chipPdN) begin
    if (!chipPdN) stateQ <= PS_OFF;
    else          stateQ <= stateNext;
  end

  always_comb begin
    strobe.cntClear = (stateNext == PS_WAKE) && (stateQ != PS_WAKE);
    strobe.cntStep  = (stateQ == PS_WAKE);
    strobe.clrSet   = (stateNext == PS_WAKE) &&
                      ((stateQ == PS_OFF) || (stateQ == PS_DEEP));
    strobe.clrDrop  = ((stateQ == PS_WAKE) && (stateNext == PS_ON)) ||
                      ((stateQ == PS_SLEEP) && (stateNext == PS_WAKE));
    strobe.gateLoad = (stateNext == PS_ON);
  end

  assign xtalEn    = (stateQ == PS_WAKE) || (stateQ == PS_ON);
  assign pllEn     = (stateQ == PS_WAKE) || (stateQ == PS_ON);
  assign mainPwrEn = (stateQ == PS_WAKE) || (stateQ == PS_ON) || (stateQ == PS_SLEEP);
  assign regClear  = (stateQ == PS_OFF) || ((stateQ == PS_WAKE) && clrHeld);

  p_off_exit_r2: assert property (@(posedge clk) disable iff (!chipPdN)
    (stateQ == PS_OFF) |=> (stateQ == PS_WAKE));

  p_on_from_wake_r3: assert property (@(posedge clk) disable iff (!chipPdN)
    $rose(stateQ == PS_ON) |-> ($past(stateQ) == PS_WAKE));

  p_deep_first_r4: assert property (@(posedge clk) disable iff (!chipPdN)
    ((stateQ == PS_ON) && deepSleepReq) |=> (stateQ == PS_DEEP));

  p_sleep_exit_r5: assert property (@(posedge clk) disable iff (!chipPdN)
    ((stateQ == PS_SLEEP) && anyWake) |=> (stateQ == PS_WAKE));

  p_deep_hold_r6: assert property (@(posedge clk) disable iff (!chipPdN)
    ((stateQ == PS_DEEP) && !wakeRtc && !wakeExt) |=> (stateQ == PS_DEEP));

  p_xtal_before_on_r3: assert property (@(posedge clk) disable iff (!chipPdN)
    $rose(stateQ == PS_ON) |-> $past(xtalEn));

endmodule

// File: rtl/pwr_seq_dp.sv
module pwr_seq_dp
  import pwr_seq_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int SETTLE_DEF = 64,
  parameter int NBLK       = 8
) (
  input  logic             clk,
  input  logic             chipPdN,
  input  seqStrobe_t       strobe,
  input  logic [CNT_W-1:0] settleCycles,
  input  logic [NBLK-1:0]  clkCtrl,
  output logic             settleDone,
  output logic             clrHeld,
  output logic [NBLK-1:0]  blkEnQ
);

  localparam logic [CNT_W-1:0] DEF_COUNT = CNT_W'(SETTLE_DEF);

  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] target;
  logic [CNT_W:0]   cntPlus;

  assign target     = (settleCycles == '0) ? DEF_COUNT : settleCycles;
  assign cntPlus    = {1'b0, cntQ} + 1'b1;
  assign settleDone = strobe.cntStep && (cntPlus >= {1'b0, target});

  always_ff @(posedge clk or negedge chipPdN) begin
    if (!chipPdN)             cntQ <= '0;
    else if (strobe.cntClear) cntQ <= '0;
    else if (strobe.cntStep)  cntQ <= cntPlus[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge chipPdN) begin
    if (!chipPdN)            clrHeld <= 1'b1;
    else if (strobe.clrSet)  clrHeld <= 1'b1;
    else if (strobe.clrDrop) clrHeld <= 1'b0;
  end

  always_ff @(posedge clk or negedge chipPdN) begin
    if (!chipPdN)             blkEnQ <= '0;
    else if (strobe.gateLoad) blkEnQ <= clkCtrl;
    else                      blkEnQ <= '0;
  end

  p_enable_subset_r7: assert property (@(posedge clk) disable iff (!chipPdN)
    1'b1 |=> ((blkEnQ & ~$past(clkCtrl)) == '0));

  p_count_bound_r3: assert property (@(posedge clk) disable iff (!chipPdN)
    strobe.cntStep |-> (cntQ < target));

endmodule

// File: rtl/pwr_clk_gate.sv
module pwr_clk_gate (
  input  logic hsClk,
  input  logic en,
  output logic gclk
);

  logic enLat;

  always_latch begin
    if (!hsClk) enLat = en;
  end

  assign gclk = hsClk & enLat;

endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
  import pwr_seq_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int SETTLE_DEF = 64,
  parameter int NBLK       = 8
) (
  input  logic             clk,
  input  logic             chipPdN,
  input  logic             sleepReq,
  input  logic             deepSleepReq,
  input  logic             wakeMac,
  input  logic             wakeHost,
  input  logic             wakeRtc,
  input  logic             wakeExt,
  input  logic [CNT_W-1:0] settleCycles,
  input  logic [NBLK-1:0]  clkCtrl,
  input  logic             hsClk,
  output logic             xtalEn,
  output logic             pllEn,
  output logic             mainPwrEn,
  output logic             regClear,
  output logic [NBLK-1:0]  blkClkEn,
  output logic [NBLK-1:0]  blkClk,
  output logic [2:0]       pwrState
);

  pwrState_t  stateQ;
  seqStrobe_t strobe;
  logic       settleDone;
  logic       clrHeld;

  pwr_seq_ctrl u_ctrl (
    .clk          (clk),
    .chipPdN      (chipPdN),
    .sleepReq     (sleepReq),
    .deepSleepReq (deepSleepReq),
    .wakeMac      (wakeMac),
    .wakeHost     (wakeHost),
    .wakeRtc      (wakeRtc),
    .wakeExt      (wakeExt),
    .settleDone   (settleDone),
    .clrHeld      (clrHeld),
    .stateQ       (stateQ),
    .strobe       (strobe),
    .xtalEn       (xtalEn),
    .pllEn        (pllEn),
    .mainPwrEn    (mainPwrEn),
    .regClear     (regClear)
  );

  pwr_seq_dp #(
    .CNT_W      (CNT_W),
    .SETTLE_DEF (SETTLE_DEF),
    .NBLK       (NBLK)
  ) u_dp (
    .clk          (clk),
    .chipPdN      (chipPdN),
    .strobe       (strobe),
    .settleCycles (settleCycles),
    .clkCtrl      (clkCtrl),
    .settleDone   (settleDone),
    .clrHeld      (clrHeld),
    .blkEnQ       (blkClkEn)
  );

  for (genvar gi = 0; gi < NBLK; gi++) begin : g_gate
    pwr_clk_gate u_gate (
      .hsClk (hsClk),
      .en    (blkClkEn[gi]),
      .gclk  (blkClk[gi])
    );
  end

  assign pwrState = stateQ;

  p_en_only_on_r7: assert property (@(posedge clk) disable iff (!chipPdN)
    (blkClkEn != '0) |-> (pwrState == 3'd4));

endmodule

// File: tb/pwr_mode_seq_bench.sv
`timescale 1ns/1ps
module pwr_mode_seq_bench;

  localparam logic [2:0] S_OFF = 3'd0, S_DEEP = 3'd1, S_SLEEP = 3'd2,
                         S_WAKE = 3'd3, S_ON = 3'd4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        chipPdN = 1'b0;
  logic        sleepReq = 1'b0, deepSleepReq = 1'b0;
  logic        wakeMac = 1'b0, wakeHost = 1'b0, wakeRtc = 1'b0, wakeExt = 1'b0;
  logic [15:0] settleCycles = 16'd3;
  logic [7:0]  clkCtrl = 8'hA5;
  logic        xtalEn, pllEn, mainPwrEn, regClear;
  logic [7:0]  blkClkEn, blkClk;
  logic [2:0]  pwrState;

  pwr_mode_seq u_pwr_mode_seq (
    .clk(clk), .chipPdN(chipPdN), .sleepReq(sleepReq), .deepSleepReq(deepSleepReq),
    .wakeMac(wakeMac), .wakeHost(wakeHost), .wakeRtc(wakeRtc), .wakeExt(wakeExt),
    .settleCycles(settleCycles), .clkCtrl(clkCtrl), .hsClk(clk),
    .xtalEn(xtalEn), .pllEn(pllEn), .mainPwrEn(mainPwrEn), .regClear(regClear),
    .blkClkEn(blkClkEn), .blkClk(blkClk), .pwrState(pwrState)
  );

  typedef struct {
    logic [2:0] st;
    logic       clr;
    logic [7:0] en;
    string      tag;
  } expItem_t;

  expItem_t expQ[$];
  int checks = 0;
  int fails  = 0;
  logic [7:0] lowEn = 8'h00;
  logic running = 1'b1;

  // driver: inputs are already set; record the result expected after the next edge
  task automatic cyc(input logic [2:0] st, input logic clr, input logic [7:0] en,
                     input string tag, input int n = 1);
    for (int k = 0; k < n; k++) begin
      expItem_t it;
      it.st = st; it.clr = clr; it.en = en; it.tag = tag;
      expQ.push_back(it);
      @(negedge clk);
    end
  endtask

  // monitor: enable seen in the low phase
  always @(negedge clk) begin
    #0.5 lowEn = blkClkEn;
  end

  // monitor: gated clock in the high phase, then scoreboard pop
  always @(posedge clk) begin
    if (running) begin
      #0.5;
      checks++;
      if (blkClk !== lowEn) begin
        fails++;
        $display("FAIL R8 blkClk actual %h expected %h", blkClk, lowEn);
      end
      #0.5;
      if (expQ.size() > 0) begin
        expItem_t it;
        logic xe, me;
        it = expQ.pop_front();
        xe = (it.st == S_WAKE) || (it.st == S_ON);
        me = xe || (it.st == S_SLEEP);
        checks++;
        if (pwrState !== it.st || regClear !== it.clr || blkClkEn !== it.en ||
            xtalEn !== xe || pllEn !== xe || mainPwrEn !== me) begin
          fails++;
          $display("FAIL %s actual st=%0d clr=%b en=%h x=%b p=%b m=%b expected st=%0d clr=%b en=%h x=%b p=%b m=%b",
                   it.tag, pwrState, regClear, blkClkEn, xtalEn, pllEn, mainPwrEn,
                   it.st, it.clr, it.en, xe, xe, me);
        end
      end
    end
  end

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog expired actual running expected finished");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    // R1 and R9: held in off
    cyc(S_OFF, 1'b1, 8'h00, "R1 R9 off under power-down", 3);
    // R2: release, wakeup with clear; R3 settle of 3; R10 request ignored
    chipPdN = 1'b1;
    cyc(S_WAKE, 1'b1, 8'h00, "R2 off to wakeup");
    sleepReq = 1'b1; deepSleepReq = 1'b1;
    cyc(S_WAKE, 1'b1, 8'h00, "R10 request in wakeup ignored");
    sleepReq = 1'b0; deepSleepReq = 1'b0;
    cyc(S_WAKE, 1'b1, 8'h00, "R3 third settle cycle");
    cyc(S_ON, 1'b0, 8'hA5, "R3 R7 on after settle", 2);
    // R7: control word change shows one cycle later
    clkCtrl = 8'h3C;
    cyc(S_ON, 1'b0, 8'h3C, "R7 control word update");
    cyc(S_ON, 1'b0, 8'h3C, "R4 stays on without request");
    // R4: deep has priority
    sleepReq = 1'b1; deepSleepReq = 1'b1;
    cyc(S_DEEP, 1'b0, 8'h00, "R4 deep over sleep");
    sleepReq = 1'b0; deepSleepReq = 1'b0;
    // R6: MAC and host ignored in deep sleep
    wakeMac = 1'b1;
    cyc(S_DEEP, 1'b0, 8'h00, "R6 mac wake ignored in deep");
    wakeMac = 1'b0; wakeHost = 1'b1;
    cyc(S_DEEP, 1'b0, 8'h00, "R6 host wake ignored in deep");
    wakeHost = 1'b0; wakeRtc = 1'b1;
    cyc(S_WAKE, 1'b1, 8'h00, "R6 rtc leaves deep with clear");
    wakeRtc = 1'b0;
    cyc(S_WAKE, 1'b1, 8'h00, "R6 clear held in wakeup", 2);
    cyc(S_ON, 1'b0, 8'h3C, "R3 on after deep wake");
    // R4 and R5: light sleep
    sleepReq = 1'b1;
    cyc(S_SLEEP, 1'b0, 8'h00, "R4 sleep request");
    sleepReq = 1'b0;
    cyc(S_SLEEP, 1'b0, 8'h00, "R5 sleep holds", 2);
    wakeHost = 1'b1;
    cyc(S_WAKE, 1'b0, 8'h00, "R5 host wake no clear");
    wakeHost = 1'b0;
    cyc(S_WAKE, 1'b0, 8'h00, "R5 wakeup from sleep", 2);
    cyc(S_ON, 1'b0, 8'h3C, "R5 back on");
    // R6: external wake from deep sleep
    deepSleepReq = 1'b1;
    cyc(S_DEEP, 1'b0, 8'h00, "R4 deep request");
    deepSleepReq = 1'b0; wakeExt = 1'b1;
    cyc(S_WAKE, 1'b1, 8'h00, "R6 external leaves deep");
    wakeExt = 1'b0;
    cyc(S_WAKE, 1'b1, 8'h00, "R6 wakeup", 2);
    cyc(S_ON, 1'b0, 8'h3C, "R6 on");
    // R3: settle of one cycle
    settleCycles = 16'd1; sleepReq = 1'b1;
    cyc(S_SLEEP, 1'b0, 8'h00, "R4 sleep");
    sleepReq = 1'b0; wakeMac = 1'b1;
    cyc(S_WAKE, 1'b0, 8'h00, "R3 single settle cycle");
    wakeMac = 1'b0; clkCtrl = 8'h81;
    cyc(S_ON, 1'b0, 8'h81, "R3 on after one cycle");
    // R3: zero selects 64
    settleCycles = 16'd0; sleepReq = 1'b1;
    cyc(S_SLEEP, 1'b0, 8'h00, "R4 sleep");
    sleepReq = 1'b0; wakeRtc = 1'b1;
    cyc(S_WAKE, 1'b0, 8'h00, "R3 default settle start");
    wakeRtc = 1'b0;
    cyc(S_WAKE, 1'b0, 8'h00, "R3 default settle", 63);
    cyc(S_ON, 1'b0, 8'h81, "R3 on after 64");
    // R7: all blocks gated off
    clkCtrl = 8'h00;
    cyc(S_ON, 1'b0, 8'h00, "R7 all gated");
    clkCtrl = 8'hFF;
    cyc(S_ON, 1'b0, 8'hFF, "R7 all open");
    // R1: power-down acts at once
    chipPdN = 1'b0;
    cyc(S_OFF, 1'b1, 8'h00, "R1 asynchronous power-down", 2);
    running = 1'b0;
    #1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule